// File: doc/BRIEF.md
# Bang-Bang PLL Proportional-Integral Loop Filter

This block is the digital loop filter of a bang-bang phase-locked loop. Once per reference cycle the phase detector delivers a single early/late decision. The filter turns that stream into a 10-bit oscillator control code. The code is the sum of two terms. The first is an integral term held in an accumulator that carries two hidden fractional bits. The second is a proportional term of fixed magnitude two.

Because of the fractional bits, the visible integral code moves only after four net decisions in one direction. This gives an effective integral gain of one quarter of a code step. Both gains stay small because acquisition has already removed most of the frequency and phase error by the time tracking starts. When the acquisition search finishes, its code is preloaded into the integrator so that tracking begins from that code. All state moves only on a strobe, so the output is stable between reference-cycle updates.

Top module: `bbpll_pi_filter`

## Requirements
- R1: After reset the integral accumulator holds RESET_CODE (default 512) with zero fraction. The proportional term is zero, so `code_o` reads 512.
- R2: When neither `upd_i` nor `load_i` is high on a clock edge, `code_o` and all internal state keep their values.
- R3: Each update moves the 12-bit accumulator by one fractional unit (a quarter code step): up when `dir_up_i`=1, down when it is 0. After a load of X, four UP updates give codes X+2, X+2, X+2, X+3.
- R4: The proportional term is +2 after an update with `dir_up_i`=1 and -2 after an update with `dir_up_i`=0. It is added to the integral code.
- R5: On any update, the new `code_o` differs from the integral code held before that update by at most three steps.
- R6: A load sets the accumulator to `load_code_i` with zero fraction and clears the proportional term. `code_o` equals `load_code_i` after that edge.
- R7: When `load_i` and `upd_i` are both high on the same edge, the load wins and the update is dropped.
- R8: `code_o` is clamped to the range 0 to 1023. For example, integral 0 with proportional -2 gives 0, and integral 1023 with +2 gives 1023.
- R9: The accumulator saturates at 0 and at 4095 instead of wrapping. From a load of 1023, four UP updates give 1023 each time, and a following DN gives 1021.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_i | input | 1 | Update strobe, one per reference cycle |
| dir_up_i | input | 1 | Phase decision: 1 = UP, 0 = DN |
| load_i | input | 1 | Preload strobe for the integrator |
| load_code_i | input | 10 | Code to preload (acquisition result) |
| code_o | output | 10 | Oscillator control code |

## Verification
The filter is driven with several kinds of decision pattern, and each one separates a different fault.

- Single UP/DN decisions and idle gaps check the proportional sign and the hold between updates.
- Runs of four and of forty same-direction decisions show whether the quarter-step integral is present, since a full-step integrator would move the code four times faster.
- Alternating decisions after a preload check the three-step bound and the behaviour of the fractional bits when the direction reverses.
- Preloads near 0 and 1023, followed by decisions that push outward, tell output clamping apart from accumulator saturation: an accumulator that wraps shows up as a jump to the opposite end of the range.

// File: rtl/pif_pkg.sv
package pif_pkg;
    localparam int DEF_CODE_W    = 10;
    localparam int DEF_FRAC_W    = 2;
    localparam int DEF_PROP_GAIN = 2;
    localparam int DEF_RST_CODE  = 512;

    typedef enum logic {
        DIR_DN = 1'b0,
        DIR_UP = 1'b1
    } dir_e;
endpackage

// File: rtl/pif_integrator.sv
module pif_integrator
    import pif_pkg::*;
#(
    parameter int CODE_W   = DEF_CODE_W,
    parameter int FRAC_W   = DEF_FRAC_W,
    parameter int RST_CODE = DEF_RST_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  logic              dir_up_i,
    input  logic              load_i,
    input  logic [CODE_W-1:0] load_code_i,
    output logic [CODE_W-1:0] int_code_o
);
    localparam int ACC_W = CODE_W + FRAC_W;
    localparam logic [ACC_W-1:0] ACC_MAX = '1;
    localparam logic [ACC_W-1:0] ACC_RST = {CODE_W'(RST_CODE), {FRAC_W{1'b0}}};

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } int_st_t;

    int_st_t s_d, s_q;
    dir_e    dir;

    assign dir = dir_e'(dir_up_i);

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.acc = {load_code_i, {FRAC_W{1'b0}}};
        end else if (upd_i) begin
            if (dir == DIR_UP) begin
                if (s_q.acc != ACC_MAX) s_d.acc = s_q.acc + ACC_W'(1);
            end else begin
                if (s_q.acc != '0) s_d.acc = s_q.acc - ACC_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{acc: ACC_RST};
        else        s_q <= s_d;
    end

    assign int_code_o = s_q.acc[ACC_W-1:FRAC_W];

    assert_int_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_i && !load_i) |=> $stable(s_q.acc));

    assert_int_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !load_i) |=>
            ((s_q.acc == $past(s_q.acc) + ACC_W'(1)) ||
             (s_q.acc + ACC_W'(1) == $past(s_q.acc)) ||
             (s_q.acc == $past(s_q.acc) && (s_q.acc == ACC_MAX || s_q.acc == '0))));

    assert_int_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (s_q.acc == {$past(load_code_i), {FRAC_W{1'b0}}}));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !load_i && dir_up_i && s_q.acc == ACC_MAX) |=> (s_q.acc == ACC_MAX));

    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !load_i && !dir_up_i && s_q.acc == '0) |=> (s_q.acc == '0));
endmodule

// File: rtl/pif_prop.sv
module pif_prop
    import pif_pkg::*;
#(
    parameter int PROP_GAIN = DEF_PROP_GAIN,
    parameter int PROP_W    = $clog2(PROP_GAIN + 1) + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     upd_i,
    input  logic                     dir_up_i,
    input  logic                     load_i,
    output logic signed [PROP_W-1:0] prop_o
);
    localparam logic signed [PROP_W-1:0] P_POS = PROP_W'(PROP_GAIN);
    localparam logic signed [PROP_W-1:0] P_NEG = -P_POS;

    typedef struct packed {
        logic signed [PROP_W-1:0] term;
    } prop_st_t;

    prop_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i)     s_d.term = '0;
        else if (upd_i) s_d.term = (dir_e'(dir_up_i) == DIR_UP) ? P_POS : P_NEG;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{term: '0};
        else        s_q <= s_d;
    end

    assign prop_o = s_q.term;

    assert_prop_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !load_i) |=> (s_q.term == ($past(dir_up_i) ? P_POS : P_NEG)));

    assert_prop_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (s_q.term == '0));
endmodule

// File: rtl/pif_combine.sv
module pif_combine #(
    parameter int CODE_W = 10,
    parameter int PROP_W = 4
) (
    input  logic [CODE_W-1:0]        int_code_i,
    input  logic signed [PROP_W-1:0] prop_i,
    output logic [CODE_W-1:0]        code_o
);
    localparam int SUM_W = CODE_W + 2;
    localparam logic signed [SUM_W-1:0] CODE_MAX = SUM_W'((1 << CODE_W) - 1);

    logic signed [SUM_W-1:0] sum;

    always_comb begin
        sum = $signed({2'b00, int_code_i}) +
              $signed({{(SUM_W-PROP_W){prop_i[PROP_W-1]}}, prop_i});
        if (sum < 0)              code_o = '0;
        else if (sum > CODE_MAX)  code_o = '1;
        else                      code_o = sum[CODE_W-1:0];
    end
endmodule

// File: rtl/bbpll_pi_filter.sv
module bbpll_pi_filter
    import pif_pkg::*;
#(
    parameter int CODE_W    = DEF_CODE_W,
    parameter int FRAC_W    = DEF_FRAC_W,
    parameter int PROP_GAIN = DEF_PROP_GAIN,
    parameter int RST_CODE  = DEF_RST_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  logic              dir_up_i,
    input  logic              load_i,
    input  logic [CODE_W-1:0] load_code_i,
    output logic [CODE_W-1:0] code_o
);
    localparam int PROP_W = $clog2(PROP_GAIN + 1) + 2;

    logic [CODE_W-1:0]        int_code;
    logic signed [PROP_W-1:0] prop_term;

    pif_integrator #(
        .CODE_W  (CODE_W),
        .FRAC_W  (FRAC_W),
        .RST_CODE(RST_CODE)
    ) u_int (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_i      (upd_i),
        .dir_up_i   (dir_up_i),
        .load_i     (load_i),
        .load_code_i(load_code_i),
        .int_code_o (int_code)
    );

    pif_prop #(
        .PROP_GAIN(PROP_GAIN),
        .PROP_W   (PROP_W)
    ) u_prop (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_i   (upd_i),
        .dir_up_i(dir_up_i),
        .load_i  (load_i),
        .prop_o  (prop_term)
    );

    pif_combine #(
        .CODE_W(CODE_W),
        .PROP_W(PROP_W)
    ) u_comb (
        .int_code_i(int_code),
        .prop_i    (prop_term),
        .code_o    (code_o)
    );

    assert_step_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !load_i) |=>
            ((int'(code_o) - int'($past(int_code)) <= PROP_GAIN + 1) &&
             (int'($past(int_code)) - int'(code_o) <= PROP_GAIN + 1)));

    assert_load_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (code_o == $past(load_code_i)));

    assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_i && !load_i) |=> $stable(code_o));
endmodule

// File: tb/sim_bbpll_pi_filter.sv
module sim_bbpll_pi_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_i = 1'b0;
    logic       dir_up_i = 1'b0;
    logic       load_i = 1'b0;
    logic [9:0] load_code_i = '0;
    logic [9:0] code_o;

    always #2 clk = ~clk;

    bbpll_pi_filter u0 (
        .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .dir_up_i(dir_up_i),
        .load_i(load_i), .load_code_i(load_code_i), .code_o(code_o)
    );

    typedef struct {
        int    exp;
        string req;
    } item_t;

    item_t q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 0;
    int    m_acc;
    int    m_prop;

    function automatic int clamp_code(int v);
        if (v < 0) return 0;
        if (v > 1023) return 1023;
        return v;
    endfunction

    task automatic step(input bit upd, input bit up, input bit ld,
                        input int ldc, input string req);
        item_t it;
        @(negedge clk);
        upd_i = upd; dir_up_i = up; load_i = ld; load_code_i = 10'(ldc);
        if (ld) begin
            m_acc = ldc * 4; m_prop = 0;
        end else if (upd) begin
            if (up) begin
                if (m_acc < 4095) m_acc++;
                m_prop = 2;
            end else begin
                if (m_acc > 0) m_acc--;
                m_prop = -2;
            end
        end
        it.exp = clamp_code(m_acc / 4 + m_prop);
        it.req = req;
        q.push_back(it);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_vec++;
                if (int'(code_o) != it.exp) begin
                    n_bad++;
                    $display("FAIL %s: code_o=%0d expected=%0d", it.req, code_o, it.exp);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : driver
        m_acc = 512 * 4; m_prop = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, "R1 reset code");
        step(1, 1, 0, 0, "R4 up adds two");
        step(1, 0, 0, 0, "R4 dn subtracts two");
        step(0, 1, 0, 0, "R2 hold idle");
        step(0, 0, 0, 0, "R2 hold idle");
        step(0, 0, 1, 300, "R6 load code");
        for (int i = 0; i < 4; i++) step(1, 1, 0, 0, "R3 quarter step up");
        step(1, 0, 0, 0, "R3 fraction after reversal");
        for (int i = 0; i < 6; i++) step(1, i % 2, 0, 0, "R5 alternating bound");
        step(1, 0, 1, 700, "R7 load beats update");
        step(0, 0, 0, 0, "R7 hold after load");
        step(0, 0, 1, 100, "R6 load low code");
        for (int i = 0; i < 40; i++) step(1, 1, 0, 0, "R3 long up run");
        for (int i = 0; i < 40; i++) step(1, 0, 0, 0, "R3 long dn run");
        step(0, 0, 1, 1023, "R6 load top");
        for (int i = 0; i < 4; i++) step(1, 1, 0, 0, "R9 accumulator top saturation");
        step(1, 0, 0, 0, "R9 dn after top saturation");
        step(0, 0, 1, 0, "R6 load zero");
        step(1, 0, 0, 0, "R8 clamp at zero");
        step(1, 0, 0, 0, "R9 accumulator bottom saturation");
        step(1, 1, 0, 0, "R9 up after bottom saturation");
        step(0, 0, 1, 1, "R6 load one");
        step(1, 0, 0, 0, "R8 clamp negative sum");
        step(0, 0, 1, 1022, "R6 load near top");
        step(1, 1, 0, 0, "R8 clamp above top");
        step(0, 0, 0, 0, "R2 hold after clamp");
        wait (q.size() == 0);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule